// File: doc/BRIEF.md
# Compare-Match Timer Channel Array

A bank of identical timer channels behind one small register bus. Every channel has an up-counter, a compare register and a control/status register. Counters advance on a slow tick that one shared prescaler derives from the bus clock. A channel counts only while its bit in a shared run register is set. When a counter sits at its compare value on a tick, it returns to zero on that tick and latches a sticky match flag. The repeat period is therefore the compare value plus one ticks.

A parameter picks one of two channel variants. In the wide variant the counter and compare registers are 32 bits, the registers are spaced four bytes apart and the prescaler divides by 8. The wide variant also has an overrun flag, which records a match that arrives while the match flag is still set. In the narrow variant the counter and compare registers are 16 bits, the registers are spaced two bytes apart and the prescaler divides by 512. Software writes to a counter are carried into the slow timebase and take effect two ticks later. Each channel drives an interrupt line, which is high while its match flag and its interrupt enable are both set.

Top module: `cmt_array`

## Requirements
- R1: After reset all run bits are 0, every counter reads 0, every control/status register reads 0, every compare register reads all ones and every irq line is low.
- R2: Bit c of the run register (byte address 0x00) runs channel c when it is 1. When it is 0 the counter holds its value.
- R3: Channel c occupies byte addresses 0x10*(c+1) onward. Control/status is at register index 0, the counter at index 1 and the compare value at index 2. The byte offset is the index times 4 in the wide variant and times 2 in the narrow variant. Any other address reads 0 and ignores writes.
- R4: A running counter advances by one once every 8 bus clocks in the wide variant and once every 512 in the narrow variant.
- R5: A counter that equals its compare value on a tick becomes 0 on that tick, so the period is the compare value plus one ticks.
- R6: That tick also sets the match flag, which is bit 15 of control/status in the wide variant and bit 7 in the narrow variant. The flag stays set until software clears it.
- R7: A control/status write clears a flag whose bit is written 0 and leaves it unchanged when the bit is written 1. A match in the same cycle as a clearing write leaves the flag set.
- R8: In the wide variant, bit 14 of control/status is an overrun flag. It is set by a match that arrives while the match flag is already set, and it is cleared in the same way as the match flag.
- R9: A counter write lands on the second tick after the write, whether or not the channel runs. Until then the counter reads its previous value.
- R10: irq[c] is high exactly when channel c has its match flag set and its enable bit (control/status bit 0) set. Writing 0 to control/status drops irq[c] at the next edge.
- R11: A compare write takes effect at the next tick. A counter already above the new value keeps counting without a match until it wraps past its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data appears on bus_rdata the next cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, 0 after a cycle without a read |
| irq | output | NUM_CH | Per-channel interrupt, match flag AND enable |

## Verification
The assertions assume that reset is held for at least one clock edge before any bus traffic. They also assume that a control/status write is the only way software can clear a flag, so a flag that is not written must stay set. The bench keeps to this by holding reset for several cycles at start-up and by driving each strobe for exactly one cycle, set up at the falling edge. The random phase aims clearing writes at a channel with a short period, so that clearing writes and matches in the same cycle do occur.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  typedef enum logic [1:0] {
    IDX_CTRL = 2'd0,
    IDX_CNT  = 2'd1,
    IDX_CMP  = 2'd2
  } reg_idx_e;

  localparam int BLK_SHIFT = 4;   // 16-byte block per channel
  localparam int IE_BIT    = 0;
  localparam int OVR_BIT   = 14;

  function automatic int unsigned div_for(input bit wide);
    return wide ? 8 : 512;
  endfunction

  function automatic int unsigned flag_bit(input bit wide);
    return wide ? 15 : 7;
  endfunction
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
  logic [W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else if (div_q == W'(DIV - 1)) div_q <= '0;
    else div_q <= div_q + 1'b1;
  end

  assign tick = (div_q == W'(DIV - 1));
endmodule

// File: rtl/cmt_decode.sv
module cmt_decode
  import cmt_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8,
  parameter int SHIFT  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              start_hit,
  output logic [NUM_CH-1:0] ch_hit,
  output reg_idx_e          idx
);
  localparam int BW = ADDR_W - BLK_SHIFT;
  logic [BW-1:0]        blk;
  logic [BLK_SHIFT-1:0] off;
  logic [BLK_SHIFT-1:0] ridx;
  logic                 aligned;

  assign blk       = addr[ADDR_W-1:BLK_SHIFT];
  assign off       = addr[BLK_SHIFT-1:0];
  assign ridx      = off >> SHIFT;
  assign aligned   = ((off & BLK_SHIFT'((1 << SHIFT) - 1)) == '0) && (ridx < 3);
  assign start_hit = (blk == '0) && (off == '0);
  assign idx       = reg_idx_e'(ridx[1:0]);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
    assign ch_hit[c] = aligned && (blk == BW'(c + 1));
  end
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int CW   = 32,
  parameter bit WIDE = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          run,
  input  logic          wr_ctrl,
  input  logic          wr_cnt,
  input  logic          wr_cmp,
  input  logic [31:0]   wdata,
  output logic [31:0]   ctrl_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cmp_o,
  output logic          flag_o,
  output logic          ld_o,
  output logic          irq_o
);
  localparam int FB = flag_bit(WIDE);

  logic [CW-1:0] cnt_q, cmp_q, pend_q;
  logic [1:0]    stage_q;
  logic          flag_q, ovr_q, ie_q;
  logic          ld, match;

  assign ld    = tick && (stage_q == 2'd2);
  assign match = tick && run && !ld && (cnt_q == cmp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      cmp_q   <= '1;
      pend_q  <= '0;
      stage_q <= 2'd0;
      flag_q  <= 1'b0;
      ie_q    <= 1'b0;
    end else begin
      if (ld) cnt_q <= pend_q;
      else if (tick && run) cnt_q <= match ? '0 : cnt_q + 1'b1;

      if (wr_cnt) begin
        pend_q  <= wdata[CW-1:0];
        stage_q <= 2'd1;
      end else if (tick && stage_q != 2'd0) begin
        stage_q <= (stage_q == 2'd1) ? 2'd2 : 2'd0;
      end

      if (wr_cmp) cmp_q <= wdata[CW-1:0];
      if (wr_ctrl) ie_q <= wdata[IE_BIT];
      flag_q <= match | (flag_q & (!wr_ctrl | wdata[FB]));
    end
  end

  if (WIDE) begin : g_ovr
    always_ff @(posedge clk) begin
      if (rst) ovr_q <= 1'b0;
      else ovr_q <= (match & flag_q) | (ovr_q & (!wr_ctrl | wdata[OVR_BIT]));
    end
  end else begin : g_no_ovr
    assign ovr_q = 1'b0;
  end

  always_comb begin
    ctrl_o          = '0;
    ctrl_o[FB]      = flag_q;
    ctrl_o[IE_BIT]  = ie_q;
    if (WIDE) ctrl_o[OVR_BIT] = ovr_q;
  end

  assign cnt_o  = cnt_q;
  assign cmp_o  = cmp_q;
  assign flag_o = flag_q;
  assign ld_o   = ld;
  assign irq_o  = flag_q & ie_q;
endmodule

// File: rtl/cmt_array.sv
module cmt_array
  import cmt_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter bit WIDE   = 1'b1,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int CW    = WIDE ? 32 : 16;
  localparam int SHIFT = WIDE ? 2 : 1;
  localparam int DIV   = div_for(WIDE);

  logic                       tick, start_hit;
  logic [NUM_CH-1:0]          ch_hit, run_q, flag_v, ld_v, ctrl_wr_v;
  reg_idx_e                   idx;
  logic [NUM_CH-1:0][31:0]    ctrl_a;
  logic [NUM_CH-1:0][CW-1:0]  cnt_a, cmp_a;
  logic [31:0]                rd_val;

  cmt_prescaler #(.DIV(DIV)) u_div (.clk(clk), .rst(rst), .tick(tick));

  cmt_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .SHIFT(SHIFT)) u_dec (
    .addr(bus_addr[ADDR_W-1:0]), .start_hit(start_hit), .ch_hit(ch_hit), .idx(idx)
  );

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else if (bus_wr && start_hit) run_q <= bus_wdata[NUM_CH-1:0];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ctrl_wr_v[c] = bus_wr && ch_hit[c] && (idx == IDX_CTRL);
    cmt_channel #(.CW(CW), .WIDE(WIDE)) u_ch (
      .clk(clk), .rst(rst), .tick(tick), .run(run_q[c]),
      .wr_ctrl(ctrl_wr_v[c]),
      .wr_cnt(bus_wr && ch_hit[c] && (idx == IDX_CNT)),
      .wr_cmp(bus_wr && ch_hit[c] && (idx == IDX_CMP)),
      .wdata(bus_wdata),
      .ctrl_o(ctrl_a[c]), .cnt_o(cnt_a[c]), .cmp_o(cmp_a[c]),
      .flag_o(flag_v[c]), .ld_o(ld_v[c]), .irq_o(irq[c])
    );
  end

  always_comb begin
    rd_val = '0;
    if (start_hit) rd_val = 32'(run_q);
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_hit[c]) begin
        case (idx)
          IDX_CTRL: rd_val = ctrl_a[c];
          IDX_CNT:  rd_val = 32'(cnt_a[c]);
          IDX_CMP:  rd_val = 32'(cmp_a[c]);
          default:  rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else bus_rdata <= bus_rd ? rd_val : '0;
  end
endmodule

// File: rtl/cmt_array_chk.sv
module cmt_array_chk #(
  parameter int NUM_CH = 4,
  parameter int CW     = 32
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      tick,
  input logic [NUM_CH-1:0]         run_q,
  input logic [NUM_CH-1:0]         ld_v,
  input logic [NUM_CH-1:0]         flag_v,
  input logic [NUM_CH-1:0]         ctrl_wr_v,
  input logic [NUM_CH-1:0]         irq,
  input logic [NUM_CH-1:0][CW-1:0] cnt_a,
  input logic [NUM_CH-1:0][CW-1:0] cmp_a
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R2: a halted channel without a pending load keeps its count
    a_r2_halt_holds: assert property (@(posedge clk) disable iff (rst)
      (!run_q[c] && !ld_v[c]) |=> (cnt_a[c] == $past(cnt_a[c])));
    // R4: no tick, no movement
    a_r4_only_on_tick: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(cnt_a[c]));
    // R5: a match returns the counter to zero
    a_r5_wrap_zero: assert property (@(posedge clk) disable iff (rst)
      (tick && run_q[c] && !ld_v[c] && cnt_a[c] == cmp_a[c]) |=> (cnt_a[c] == '0));
    // R6: the match flag is sticky without a control write
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
      (flag_v[c] && !ctrl_wr_v[c]) |=> flag_v[c]);
    // R10: an interrupt needs the flag
    a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
      irq[c] |-> flag_v[c]);
  end
endmodule

bind cmt_array cmt_array_chk #(.NUM_CH(NUM_CH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .run_q(run_q), .ld_v(ld_v),
  .flag_v(flag_v), .ctrl_wr_v(ctrl_wr_v), .irq(irq), .cnt_a(cnt_a), .cmp_a(cmp_a)
);

// File: tb/tb_cmt_array.sv
module tb_cmt_array;
  localparam int CLK_PERIOD = 10;
  localparam int N     = 4;
  localparam int DIV   = 8;
  localparam int LIMIT = 150000;

  logic        clk, rst, bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [N-1:0] irq;

  cmt_array dut (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  // behavioural reference
  logic [N-1:0] m_run;
  logic [31:0]  m_cnt[N], m_cmp[N], m_pv[N], m_rd;
  int           m_stage[N], m_pc;
  bit           m_flag[N], m_ovr[N], m_ie[N], m_rdv, tk, ld, mt;
  bit           h_ctl, h_cnt, h_cmp;

  function automatic logic [31:0] model_read(input logic [7:0] a);
    int blk, off, c;
    blk = a / 16; off = a % 16;
    if (a == 8'h00) return 32'(m_run);
    if (blk < 1 || blk > N || (off % 4) != 0 || off / 4 > 2) return 32'h0;
    c = blk - 1;
    case (off / 4)
      0: return (32'(m_flag[c]) << 15) | (32'(m_ovr[c]) << 14) | 32'(m_ie[c]);
      1: return m_cnt[c];
      default: return m_cmp[c];
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_run = '0; m_pc = 0; m_rdv = 0; m_rd = 0;
      for (int c = 0; c < N; c++) begin
        m_cnt[c] = 0; m_cmp[c] = 32'hFFFF_FFFF; m_pv[c] = 0; m_stage[c] = 0;
        m_flag[c] = 0; m_ovr[c] = 0; m_ie[c] = 0;
      end
    end else begin
      tk = (m_pc == DIV - 1);
      m_pc = tk ? 0 : m_pc + 1;
      m_rdv = bus_rd;
      if (bus_rd) m_rd = model_read(bus_addr);
      for (int c = 0; c < N; c++) begin
        h_ctl = bus_wr && bus_addr == 8'(16 * (c + 1));
        h_cnt = bus_wr && bus_addr == 8'(16 * (c + 1) + 4);
        h_cmp = bus_wr && bus_addr == 8'(16 * (c + 1) + 8);
        ld = tk && m_stage[c] == 2;
        mt = tk && m_run[c] && !ld && m_cnt[c] == m_cmp[c];
        if (ld) m_cnt[c] = m_pv[c];
        else if (tk && m_run[c]) m_cnt[c] = mt ? 0 : m_cnt[c] + 1;
        if (h_cnt) begin m_pv[c] = bus_wdata; m_stage[c] = 1; end
        else if (tk && m_stage[c] != 0) m_stage[c] = (m_stage[c] == 1) ? 2 : 0;
        m_ovr[c]  = (h_ctl ? (m_ovr[c] & bus_wdata[14]) : m_ovr[c]) | (mt & m_flag[c]);
        m_flag[c] = (h_ctl ? (m_flag[c] & bus_wdata[15]) : m_flag[c]) | mt;
        if (h_ctl) m_ie[c] = bus_wdata[0];
        if (h_cmp) m_cmp[c] = bus_wdata;
      end
      if (bus_wr && bus_addr == 8'h00) m_run = bus_wdata[N-1:0];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst) begin
      for (int c = 0; c < N; c++)
        chk(irq[c] == (m_flag[c] & m_ie[c]), "R10 irq vs model", 32'(irq[c]), 32'(m_flag[c] & m_ie[c]));
      if (m_rdv) chk(bus_rdata == m_rd, "R3 rdata vs model", bus_rdata, m_rd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= LIMIT) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] v, v1, v2;

  initial begin
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(8'h00, v); chk(v == 0, "R1 run reg", v, 0);
    rd(8'h18, v); chk(v == 32'hFFFF_FFFF, "R1 compare", v, 32'hFFFF_FFFF);
    rd(8'h14, v); chk(v == 0, "R1 counter", v, 0);
    rd(8'h10, v); chk(v == 0, "R1 ctrl", v, 0);
    chk(irq == 0, "R1 irq", 32'(irq), 0);
    // R3 unmapped space
    rd(8'h04, v); chk(v == 0, "R3 hole near run reg", v, 0);
    rd(8'h12, v); chk(v == 0, "R3 misaligned", v, 0);
    rd(8'h1C, v); chk(v == 0, "R3 index 3", v, 0);
    rd(8'h50, v); chk(v == 0, "R3 missing channel", v, 0);
    wr(8'h1C, 32'h1234);
    rd(8'h18, v); chk(v == 32'hFFFF_FFFF, "R3 ignored write", v, 32'hFFFF_FFFF);
    // R6 R8 R10: short period on channel 0
    wr(8'h18, 3); wr(8'h10, 1); wr(8'h00, 1);
    idle(100);
    rd(8'h10, v); chk(v == 32'h0000_C001, "R6 R8 flags", v, 32'h0000_C001);
    chk(irq[0] == 1'b1, "R10 irq high", 32'(irq[0]), 1);
    // R2 halt
    wr(8'h00, 0);
    rd(8'h14, v1); idle(40); rd(8'h14, v2);
    chk(v1 == v2, "R2 halted counter", v2, v1);
    // R7 clear match flag, keep overrun
    wr(8'h10, 32'h4001);
    rd(8'h10, v); chk(v == 32'h4001, "R7 selective clear", v, 32'h4001);
    chk(irq[0] == 1'b0, "R10 irq low after clear", 32'(irq[0]), 0);
    wr(8'h10, 0);
    rd(8'h10, v); chk(v == 0, "R8 R10 ctrl zero", v, 0);
    // R9 delayed counter write
    wr(8'h14, 32'h55);
    rd(8'h14, v); chk(v == v2, "R9 old value in window", v, v2);
    idle(24);
    rd(8'h14, v); chk(v == 32'h55, "R9 value landed", v, 32'h55);
    // R4 prescale on channel 1
    wr(8'h00, 2);
    rd(8'h24, v1); idle(79); rd(8'h24, v2);
    chk(v2 - v1 == 10, "R4 ten ticks in 80 clocks", v2 - v1, 10);
    // R11 compare below running counter on channel 2
    wr(8'h34, 100); idle(24);
    wr(8'h00, 6); idle(40);
    wr(8'h38, 50); idle(200);
    rd(8'h30, v); chk(v == 0, "R11 no match after passing", v, 0);
    rd(8'h34, v); chk(v > 120, "R11 counter keeps going", v, 121);
    // R5 period on channel 3
    wr(8'h48, 4); wr(8'h00, 32'hE); idle(5);
    rd(8'h44, v1); idle(39); rd(8'h44, v2);
    chk(v1 == v2, "R5 period compare+1", v2, v1);
    for (int i = 0; i < 10; i++) begin
      rd(8'h44, v); chk(v <= 4, "R5 counter bounded", v, 4);
      idle(2);
    end
    // R7 random clears against matches, compared by the model
    wr(8'h48, 1);
    for (int i = 0; i < 400; i++) begin
      case ($urandom_range(0, 2))
        0: wr(8'h40, {16'h0, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 13'h0, 1'b1});
        1: rd(8'h40, v);
        default: rd(8'h44, v);
      endcase
      idle($urandom_range(0, 5));
    end
    idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule